// File: doc/BRIEF.md
# MII Receive Length Guard and Own-Frame Filter

This block sits directly behind a 4-bit MII receive interface. It is clocked once per received nibble. It looks for the start-of-frame delimiter, pairs the nibbles that follow into bytes and hands them on as a byte stream. Each byte is marked valid, and the final byte of a frame also carries a last flag and an error flag.

A frame-length guard limits how much of any one frame is accepted. In the normal setting it accepts 2048 bytes. When the guard is relaxed it accepts 16,384 bytes. A frame that runs past the active limit is cut short. Its final delivered byte is flagged as an error, the rest of the frame is dropped, and a sticky timeout flag is raised.

In half-duplex operation the block can also reject frames that begin while the local transmitter is driving the medium. This covers the node's own transmissions and any collision traffic. The reject decision is made once, at the delimiter. It is never applied in full-duplex operation.

Top module: `mii_rx_guard`

## Requirements
- R1: A frame starts after a nibble 0x5 is followed directly by a nibble 0xD while the data-valid input is high. Preamble and delimiter nibbles never appear on the byte output.
- R2: Each output byte is built from two nibbles. The first nibble received becomes bits 3:0 and the second becomes bits 7:4.
- R3: When data-valid falls, the last complete byte of the frame is delivered with the last flag set. A trailing unpaired nibble is discarded. The last flag is only ever asserted together with valid.
- R4: With the length guard in its normal setting, a frame of up to 2048 bytes is delivered in full with the error flag clear, and the timeout flag stays clear.
- R5: With the length guard in its normal setting, a longer frame delivers exactly its first 2048 bytes. The 2048th byte carries both last and error. Nothing more is delivered until data-valid falls.
- R6: The timeout flag sets on a truncation and stays set until reset.
- R7: With the length guard relaxed, a frame of 16,384 bytes is delivered in full with no error.
- R8: In half-duplex operation with own-reception disabled, a frame whose delimiter arrives while local transmit-enable is high produces no output. A later frame with transmit-enable low is delivered.
- R9: With own-reception allowed, frames received during local transmission are delivered unchanged.
- R10: In full-duplex operation, frames are delivered whatever the own-reception setting and the transmit-enable level.
- R11: The reject decision is taken at the delimiter only. A transmit-enable that rises in the middle of an accepted frame does not affect that frame.
- R12: During and right after reset, valid, last, error and the timeout flag are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one nibble per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| mii_rxd | input | 4 | Receive nibble |
| mii_rx_dv | input | 1 | Receive data valid |
| tx_en_local | input | 1 | Local transmitter active |
| cfg_wd_off | input | 1 | 1 relaxes the length guard to the large limit |
| cfg_no_rx_own | input | 1 | 1 rejects frames starting during local transmit (half duplex) |
| cfg_full_dup | input | 1 | 1 selects full-duplex operation |
| rx_byte | output | 8 | Received byte |
| rx_valid | output | 1 | rx_byte holds a byte this cycle |
| rx_last | output | 1 | Final byte of the frame |
| rx_err | output | 1 | Frame was truncated by the length guard |
| wd_timeout | output | 1 | Sticky truncation flag |

## Verification
The hardest situation to reach is the exact length boundary. The guard has to let byte 2048 through untouched but turn the arrival of byte 2049 into an error flag on the byte before it. With the guard relaxed, a full 16,384-byte frame has to pass with no error. The driver builds frames of exactly 2048, 2049 and 16,384 bytes from a computed byte pattern and queues the expected stream, including the flags on the final byte. A monitor then compares every delivered byte. For own-frame rejection, the bench raises transmit-enable before the delimiter in the reject case. It also raises it halfway through a frame to show that the start-time decision holds.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_DATA, ST_DROP} rx_state_t;

  // Active frame-length limit in bytes.
  function automatic int unsigned frame_limit(input logic relaxed,
                                              input int unsigned std_lim,
                                              input int unsigned big_lim);
    return relaxed ? big_lim : std_lim;
  endfunction
endpackage

// File: rtl/mrg_sfd_detect.sv
module mrg_sfd_detect #(
  parameter int NIB_W = 4,
  parameter logic [2*NIB_W-1:0] SFD = 8'hD5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIB_W-1:0] rxd,
  input  logic             dv,
  output logic             sfd_seen
);
  logic [NIB_W-1:0] prev_nib;
  logic             prev_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_nib <= '0;
      prev_ok  <= 1'b0;
    end else begin
      prev_nib <= rxd;
      prev_ok  <= dv;
    end
  end

  // The low nibble of the delimiter arrives first on the wire.
  assign sfd_seen = dv && prev_ok && (prev_nib == SFD[NIB_W-1:0])
                    && (rxd == SFD[2*NIB_W-1:NIB_W]);
endmodule

// File: rtl/mrg_len_watch.sv
module mrg_len_watch
  import mrg_pkg::*;
#(
  parameter int unsigned STD_LIMIT   = 2048,
  parameter int unsigned JUMBO_LIMIT = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic byte_done,
  input  logic wd_off,
  output logic over_hit
);
  localparam int CNT_W = $clog2(JUMBO_LIMIT + 1);
  localparam int LW    = CNT_W + 1;

  logic [CNT_W-1:0] byte_cnt;
  logic [LW-1:0]    cnt_next;
  logic [LW-1:0]    lim;

  assign lim      = LW'(frame_limit(wd_off, STD_LIMIT, JUMBO_LIMIT));
  assign cnt_next = {1'b0, byte_cnt} + 1'b1;
  assign over_hit = byte_done && (cnt_next > lim);

  always_ff @(posedge clk) begin
    if (!rst_n)                     byte_cnt <= '0;
    else if (clear)                 byte_cnt <= '0;
    else if (byte_done && !over_hit) byte_cnt <= cnt_next[CNT_W-1:0];
  end

  // R7: the count never passes the largest limit
  p_cnt_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, byte_cnt} <= LW'(JUMBO_LIMIT));
endmodule

// File: rtl/mrg_own_gate.sv
module mrg_own_gate (
  input  logic frame_start,
  input  logic tx_en,
  input  logic no_rx_own,
  input  logic full_dup,
  output logic drop_frame
);
  // Decision taken only on the delimiter cycle; full duplex never rejects.
  assign drop_frame = frame_start && !full_dup && no_rx_own && tx_en;
endmodule

// File: rtl/mii_rx_guard.sv
module mii_rx_guard
  import mrg_pkg::*;
#(
  parameter int unsigned STD_LIMIT   = 2048,
  parameter int unsigned JUMBO_LIMIT = 16384,
  parameter int          NIB_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIB_W-1:0] mii_rxd,
  input  logic             mii_rx_dv,
  input  logic             tx_en_local,
  input  logic             cfg_wd_off,
  input  logic             cfg_no_rx_own,
  input  logic             cfg_full_dup,
  output logic [2*NIB_W-1:0] rx_byte,
  output logic             rx_valid,
  output logic             rx_last,
  output logic             rx_err,
  output logic             wd_timeout
);
  localparam int BYTE_W = 2 * NIB_W;

  rx_state_t         state;
  logic              phase;
  logic [NIB_W-1:0]  lo_nib;
  logic [BYTE_W-1:0] pend;
  logic              have_pend;

  logic sfd_seen, frame_start, byte_done, over_hit, own_drop;

  assign frame_start = (state == ST_HUNT) && sfd_seen;
  assign byte_done   = (state == ST_DATA) && mii_rx_dv && phase;

  mrg_sfd_detect #(.NIB_W(NIB_W), .SFD(BYTE_W'(8'hD5))) u_sfd (
    .clk(clk), .rst_n(rst_n), .rxd(mii_rxd), .dv(mii_rx_dv), .sfd_seen(sfd_seen));

  mrg_len_watch #(.STD_LIMIT(STD_LIMIT), .JUMBO_LIMIT(JUMBO_LIMIT)) u_len (
    .clk(clk), .rst_n(rst_n), .clear(frame_start), .byte_done(byte_done),
    .wd_off(cfg_wd_off), .over_hit(over_hit));

  mrg_own_gate u_own (
    .frame_start(frame_start), .tx_en(tx_en_local), .no_rx_own(cfg_no_rx_own),
    .full_dup(cfg_full_dup), .drop_frame(own_drop));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_HUNT;
      phase      <= 1'b0;
      lo_nib     <= '0;
      pend       <= '0;
      have_pend  <= 1'b0;
      rx_byte    <= '0;
      rx_valid   <= 1'b0;
      rx_last    <= 1'b0;
      rx_err     <= 1'b0;
      wd_timeout <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_last  <= 1'b0;
      rx_err   <= 1'b0;
      unique case (state)
        ST_HUNT: begin
          if (frame_start) begin
            state     <= own_drop ? ST_DROP : ST_DATA;
            phase     <= 1'b0;
            have_pend <= 1'b0;
          end
        end
        ST_DATA: begin
          if (!mii_rx_dv) begin
            if (have_pend) begin
              rx_byte  <= pend;
              rx_valid <= 1'b1;
              rx_last  <= 1'b1;
            end
            have_pend <= 1'b0;
            state     <= ST_HUNT;
          end else if (!phase) begin
            lo_nib <= mii_rxd;
            phase  <= 1'b1;
          end else begin
            phase <= 1'b0;
            if (over_hit) begin
              rx_byte    <= pend;
              rx_valid   <= 1'b1;
              rx_last    <= 1'b1;
              rx_err     <= 1'b1;
              wd_timeout <= 1'b1;
              have_pend  <= 1'b0;
              state      <= ST_DROP;
            end else begin
              if (have_pend) begin
                rx_byte  <= pend;
                rx_valid <= 1'b1;
              end
              pend      <= {mii_rxd, lo_nib};
              have_pend <= 1'b1;
            end
          end
        end
        ST_DROP: if (!mii_rx_dv) state <= ST_HUNT;
        default: state <= ST_HUNT;
      endcase
    end
  end

  // R3: last only accompanies a valid byte
  p_last_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_last |-> rx_valid);
  // R5: error marks the final delivered byte
  p_err_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> (rx_valid && rx_last));
  // R5: overrun produces error and timeout on the next cycle
  p_trunc_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    over_hit |=> (rx_err && wd_timeout));
  // R6: timeout flag is sticky
  p_timeout_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_timeout |=> wd_timeout);
  // R8: nothing leaves while a frame is being discarded
  p_drop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DROP && $past(state) == ST_DROP) |-> !rx_valid);
  // R10: full duplex always accepts the frame
  p_fulldup_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && cfg_full_dup) |=> (state == ST_DATA));
endmodule

// File: tb/tb_mii_rx_guard.sv
module tb_mii_rx_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] rxd = '0;
  logic dv = 1'b0, txen = 1'b0, wd_off = 1'b0, no_own = 1'b0, fdup = 1'b0;
  logic [7:0] rx_byte;
  logic rx_valid, rx_last, rx_err, wd_timeout;

  int n_tests = 0;
  int n_fail  = 0;
  string cur_req = "R12";
  logic [9:0] exp_q[$];

  always #5 clk = ~clk;

  mii_rx_guard dut (
    .clk(clk), .rst_n(rst_n), .mii_rxd(rxd), .mii_rx_dv(dv), .tx_en_local(txen),
    .cfg_wd_off(wd_off), .cfg_no_rx_own(no_own), .cfg_full_dup(fdup),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_last(rx_last), .rx_err(rx_err),
    .wd_timeout(wd_timeout));

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 37 + seed * 11 + (i >> 8)) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as bytes appear.
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_req, {rx_err, rx_last, rx_byte}, 0);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk({rx_err, rx_last, rx_byte} == e, cur_req, {rx_err, rx_last, rx_byte}, e);
      end
    end
  end

  task automatic nib(input logic [3:0] v, input logic d);
    @(posedge clk); #1;
    rxd = v; dv = d;
  endtask

  // tx_mode: 0 off, 1 high from before the delimiter, 2 rises mid-frame
  task automatic send_frame(input int n, input int seed, input bit extra, input int tx_mode);
    int lim, nout;
    bit pass;
    lim  = wd_off ? 16384 : 2048;
    pass = !(!fdup && no_own && tx_mode == 1);
    if (pass) begin
      nout = (n > lim) ? lim : n;
      for (int i = 0; i < nout; i++)
        exp_q.push_back({(i == nout - 1) && (n > lim), i == nout - 1, pat(i, seed)});
    end
    if (tx_mode == 1) begin @(posedge clk); #1; txen = 1'b1; end
    for (int k = 0; k < 15; k++) nib(4'h5, 1'b1);
    nib(4'hD, 1'b1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = pat(i, seed);
      if (tx_mode == 2 && i == n / 2) txen = 1'b1;
      nib(b[3:0], 1'b1);
      nib(b[7:4], 1'b1);
    end
    if (extra) nib(4'hA, 1'b1);
    nib(4'h0, 1'b0);
    txen = 1'b0;
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, {cur_req, " drained"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({rx_valid, rx_last, rx_err, wd_timeout} == 4'b0, "R12 reset",
        {rx_valid, rx_last, rx_err, wd_timeout}, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk({rx_valid, wd_timeout} == 2'b0, "R12 post-reset", {rx_valid, wd_timeout}, 0);

    cur_req = "R1 R2 basic";           send_frame(64, 1, 1'b0, 0);
    cur_req = "R3 odd nibble";         send_frame(5, 2, 1'b1, 0);
    cur_req = "R3 single byte";        send_frame(1, 3, 1'b0, 0);
    cur_req = "R4 2048";               send_frame(2048, 4, 1'b0, 0);
    chk(wd_timeout == 1'b0, "R4 timeout clear", wd_timeout, 0);
    cur_req = "R5 2049";               send_frame(2049, 5, 1'b0, 0);
    chk(wd_timeout == 1'b1, "R6 timeout set", wd_timeout, 1);
    cur_req = "R6 after";              send_frame(10, 6, 1'b0, 0);
    chk(wd_timeout == 1'b1, "R6 timeout sticky", wd_timeout, 1);
    wd_off = 1'b1;
    cur_req = "R7 16384";              send_frame(16384, 7, 1'b0, 0);
    cur_req = "R7 3000";               send_frame(3000, 8, 1'b0, 0);
    wd_off = 1'b0;
    no_own = 1'b1;
    cur_req = "R8 own dropped";        send_frame(40, 9, 1'b0, 1);
    cur_req = "R8 next passes";        send_frame(40, 10, 1'b0, 0);
    no_own = 1'b0;
    cur_req = "R9 own allowed";        send_frame(40, 11, 1'b0, 1);
    no_own = 1'b1; fdup = 1'b1;
    cur_req = "R10 full duplex";       send_frame(40, 12, 1'b0, 1);
    fdup = 1'b0;
    cur_req = "R11 tx mid-frame";      send_frame(40, 13, 1'b0, 2);

    @(posedge clk); #1; rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(wd_timeout == 1'b0, "R6 cleared by reset", wd_timeout, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule